// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block runs a guarded change of the clock division ratios. Software first programs the new divider and memory-clock settings into a staging register and writes a stabilization count. It then writes a fixed 32-bit key to the control register. The sequencer stalls the core and drives the external clock-output enable pin low. After a guard interval, it switches the external clock output to the raw, still-settling PLL clock.

The sequencer then waits for the PLL lock input, runs a second guard interval and raises the enable pin again. Next, an up-counting watchdog runs on peripheral-clock ticks until it matches the programmed count. On that match the staged settings move into the active divider outputs in one cycle, the stall is released and the control register reads zero again. The guard intervals and the watchdog count in peripheral-clock ticks, which arrive as a one-cycle `pck_tick` pulse in the system clock domain.

A change that includes a new memory-clock setting needs the external memory to be in self-refresh first. If that setting is nonzero and the self-refresh acknowledge is low, the start key is refused and a sticky error flag is raised.

Top module: `clkchg_seq`

## Requirements
- R1: Only a write of 0xCF000001 to address 0 (the control register) starts a change. A write of any other value, or a write of the key to any other address, leaves the enable pin high and the stall low, and the control register keeps reading 0.
- R2: At the clock edge that accepts the key, the enable pin `clkout_en_o` goes low and `core_stall_o` goes high. Both are visible in the next cycle.
- R3: `clkout_src_o` rises on the 10th `pck_tick` counted after the start edge. During that interval the enable pin stays low.
- R4: After `pll_lock` has been seen high, `clkout_en_o` rises on the 10th following `pck_tick`.
- R5: The 16-bit watchdog then counts `pck_tick`s from 0. The stall drops on the tick at which the count equals the compare value held at address 2, which takes compare+1 ticks. A compare value of 0 resumes on the first tick.
- R6: Address 0 reads 0xCF000001 while a change is running and 0x00000000 when idle or after completion.
- R7: The staging register at address 1 holds the divider fields in bits [11:0] and the memory-clock field in bits [19:16]. Its contents reach `div_act_o` and `mem_act_o` in the same cycle the stall drops. At no other time do these outputs change.
- R8: While a change is running, writes to any register are ignored. This includes the staging register and the compare register.
- R9: If the memory-clock staging field is nonzero and `sr_ack` is low, the key is refused. In that case `sr_err_o` (also bit 0 of address 3) becomes 1 and stays 1 until reset.
- R10: After reset the block is idle: enable pin high, stall low, source select low, active dividers 0, error 0, control register reading 0.
- R11: When the stall drops, the enable pin is high and `clkout_src_o` has returned to 0, so the new ratio is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 staging, 2 compare, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pck_tick | input | 1 | One-cycle pulse per peripheral-clock cycle |
| pll_lock | input | 1 | PLL reports stable oscillation |
| sr_ack | input | 1 | External memory is in self-refresh |
| clkout_en_o | output | 1 | External clock-output enable pin, low during the switch |
| clkout_src_o | output | 1 | 1 selects the raw PLL clock on the external clock output |
| core_stall_o | output | 1 | Holds the core stopped while a change runs |
| div_act_o | output | 12 | Active divider fields, 3 x 4 bits |
| mem_act_o | output | 4 | Active memory-clock setting |
| sr_err_o | output | 1 | Sticky refused-start error |

## Verification
Several full changes are run with compare values of 0, 5 and 40 and with different delays before PLL lock. The tick counts measured in each phase show whether each guard and the watchdog end on the right tick or one tick off. Writes made during a change use values that differ from the staged ones, so an ignored write can be told apart from an accepted one in the final divider outputs. Near-miss keys, the key at the wrong address, and a memory-clock change with and without the self-refresh acknowledge separate a correct start decode from a loose one.

// File: rtl/clkchg_pkg.sv
package clkchg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GUARD_OUT,
      ST_LOCK_WAIT,
      ST_GUARD_IN,
      ST_WDT_RUN
   } seq_state_t;

   localparam logic [1:0] A_CTRL  = 2'd0;
   localparam logic [1:0] A_STAGE = 2'd1;
   localparam logic [1:0] A_WCMP  = 2'd2;
   localparam logic [1:0] A_STAT  = 2'd3;

   localparam int MEM_LSB = 16;
endpackage

// File: rtl/clkchg_regs.sv
module clkchg_regs
   import clkchg_pkg::*;
#(
   parameter int          DIV_W   = 4,
   parameter int          NDIV    = 3,
   parameter int          MEM_W   = 4,
   parameter int          CNT_W   = 16,
   parameter logic [31:0] KEY     = 32'hCF00_0001,
   parameter int          DIV_RST = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [1:0]             reg_addr,
   input  logic [31:0]            reg_wdata,
   input  logic                   sr_ack,
   input  logic                   busy,
   input  logic                   commit,
   output logic                   start,
   output logic [CNT_W-1:0]       wdt_cmp,
   output logic [NDIV*DIV_W-1:0]  div_act,
   output logic [MEM_W-1:0]       mem_act,
   output logic                   err,
   output logic [31:0]            reg_rdata
);
   localparam int DV_BITS = NDIV * DIV_W;

   logic [DV_BITS-1:0] div_stage;
   logic [MEM_W-1:0]   mem_stage;
   logic [CNT_W-1:0]   cmp_q;
   logic               err_q;
   logic [MEM_W-1:0]   mem_q;
   logic [DIV_W-1:0]   div_q [NDIV];

   logic key_hit, sr_ok, free_wr;

   assign key_hit = reg_wr && (reg_addr == A_CTRL) && (reg_wdata == KEY) && !busy;
   assign sr_ok   = (mem_stage == '0) || sr_ack;
   assign start   = key_hit && sr_ok;
   assign free_wr = reg_wr && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_stage <= '0;
         mem_stage <= '0;
         cmp_q     <= '0;
         err_q     <= 1'b0;
      end else begin
         if (free_wr && reg_addr == A_STAGE) begin
            div_stage <= reg_wdata[DV_BITS-1:0];
            mem_stage <= reg_wdata[MEM_LSB +: MEM_W];
         end
         if (free_wr && reg_addr == A_WCMP)
            cmp_q <= reg_wdata[CNT_W-1:0];
         if (key_hit && !sr_ok)
            err_q <= 1'b1;
      end
   end

   for (genvar f = 0; f < NDIV; f++) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            div_q[f] <= DIV_W'(DIV_RST);
         else if (commit)
            div_q[f] <= div_stage[f*DIV_W +: DIV_W];
      end
      assign div_act[f*DIV_W +: DIV_W] = div_q[f];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mem_q <= '0;
      else if (commit)
         mem_q <= mem_stage;
   end

   assign mem_act = mem_q;
   assign wdt_cmp = cmp_q;
   assign err     = err_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata = busy ? KEY : 32'h0;
         A_STAGE: begin
            reg_rdata[DV_BITS-1:0]       = div_stage;
            reg_rdata[MEM_LSB +: MEM_W]  = mem_stage;
         end
         A_WCMP:  reg_rdata[CNT_W-1:0] = cmp_q;
         default: reg_rdata[0] = err_q;
      endcase
   end
endmodule

// File: rtl/clkchg_wdt.sv
module clkchg_wdt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   output logic             match
);
   logic [CNT_W-1:0] cnt;

   assign match = run && tick && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (run && tick && !match)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/clkchg_fsm.sv
module clkchg_fsm
   import clkchg_pkg::*;
#(
   parameter int GUARD = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   input  logic pll_lock,
   input  logic match,
   output logic busy,
   output logic en_o,
   output logic src_o,
   output logic stall_o,
   output logic wdt_clr,
   output logic wdt_run
);
   localparam int GW = $clog2(GUARD + 1);

   seq_state_t    state;
   logic [GW-1:0] gcnt;
   logic          g_last;

   assign g_last = tick && (gcnt == GW'(GUARD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         gcnt    <= '0;
         en_o    <= 1'b1;
         src_o   <= 1'b0;
         stall_o <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state   <= ST_GUARD_OUT;
               gcnt    <= '0;
               en_o    <= 1'b0;
               stall_o <= 1'b1;
            end
            ST_GUARD_OUT: if (tick) begin
               if (g_last) begin
                  src_o <= 1'b1;
                  state <= ST_LOCK_WAIT;
                  gcnt  <= '0;
               end else
                  gcnt <= gcnt + 1'b1;
            end
            ST_LOCK_WAIT: if (pll_lock) begin
               state <= ST_GUARD_IN;
               gcnt  <= '0;
            end
            ST_GUARD_IN: if (tick) begin
               if (g_last) begin
                  en_o  <= 1'b1;
                  state <= ST_WDT_RUN;
               end else
                  gcnt <= gcnt + 1'b1;
            end
            ST_WDT_RUN: if (match) begin
               state   <= ST_IDLE;
               stall_o <= 1'b0;
               src_o   <= 1'b0;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign wdt_clr = start;
   assign wdt_run = (state == ST_WDT_RUN);
endmodule

// File: rtl/clkchg_seq.sv
module clkchg_seq #(
   parameter int          DIV_W   = 4,
   parameter int          NDIV    = 3,
   parameter int          MEM_W   = 4,
   parameter int          CNT_W   = 16,
   parameter int          GUARD   = 10,
   parameter logic [31:0] KEY     = 32'hCF00_0001,
   parameter int          DIV_RST = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [1:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic                  pck_tick,
   input  logic                  pll_lock,
   input  logic                  sr_ack,
   output logic                  clkout_en_o,
   output logic                  clkout_src_o,
   output logic                  core_stall_o,
   output logic [NDIV*DIV_W-1:0] div_act_o,
   output logic [MEM_W-1:0]      mem_act_o,
   output logic                  sr_err_o
);
   if (NDIV * DIV_W > 16 || NDIV < 1 || DIV_W < 1) begin : g_bad_div
      $error("divider fields must fit in 16 bits");
   end
   if (MEM_W < 1 || MEM_W > 12) begin : g_bad_mem
      $error("memory field width out of range");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("watchdog width out of range");
   end
   if (GUARD < 1) begin : g_bad_guard
      $error("guard interval must be at least one tick");
   end

   logic start, busy, commit, wdt_clr, wdt_run;
   logic [CNT_W-1:0] wdt_cmp;

   clkchg_regs #(
      .DIV_W(DIV_W), .NDIV(NDIV), .MEM_W(MEM_W), .CNT_W(CNT_W),
      .KEY(KEY), .DIV_RST(DIV_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .sr_ack(sr_ack), .busy(busy), .commit(commit),
      .start(start), .wdt_cmp(wdt_cmp), .div_act(div_act_o),
      .mem_act(mem_act_o), .err(sr_err_o), .reg_rdata(reg_rdata)
   );

   clkchg_fsm #(.GUARD(GUARD)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(pck_tick),
      .pll_lock(pll_lock), .match(commit), .busy(busy),
      .en_o(clkout_en_o), .src_o(clkout_src_o), .stall_o(core_stall_o),
      .wdt_clr(wdt_clr), .wdt_run(wdt_run)
   );

   clkchg_wdt #(.CNT_W(CNT_W)) u_wdt (
      .clk(clk), .rst_n(rst_n), .clr(wdt_clr), .run(wdt_run),
      .tick(pck_tick), .cmp(wdt_cmp), .match(commit)
   );
endmodule

// File: rtl/clkchg_seq_chk.sv
module clkchg_seq_chk #(
   parameter int          DV_BITS = 12,
   parameter logic [31:0] KEY     = 32'hCF00_0001
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [1:0]         reg_addr,
   input logic [31:0]        reg_wdata,
   input logic               sr_ack,
   input logic               clkout_en_o,
   input logic               clkout_src_o,
   input logic               core_stall_o,
   input logic [DV_BITS-1:0] div_act_o,
   input logic               sr_err_o
);
   assert_wrong_key_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_stall_o && reg_wr && reg_addr == 2'd0 && reg_wdata != KEY)
      |=> (clkout_en_o && !core_stall_o));

   assert_start_drops_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_stall_o && reg_wr && reg_addr == 2'd0 && reg_wdata == KEY && sr_ack)
      |=> (!clkout_en_o && core_stall_o));

   assert_src_under_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clkout_src_o) |-> (!clkout_en_o && core_stall_o));

   assert_en_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clkout_en_o) |-> (core_stall_o && clkout_src_o));

   assert_div_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      core_stall_o |=> (!core_stall_o || $stable(div_act_o)));

   assert_div_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !core_stall_o |=> $stable(div_act_o));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sr_err_o |=> sr_err_o);

   assert_resume_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_stall_o) |-> (clkout_en_o && !clkout_src_o));
endmodule

bind clkchg_seq clkchg_seq_chk #(.DV_BITS(NDIV*DIV_W), .KEY(KEY)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .sr_ack(sr_ack), .clkout_en_o(clkout_en_o),
   .clkout_src_o(clkout_src_o), .core_stall_o(core_stall_o),
   .div_act_o(div_act_o), .sr_err_o(sr_err_o)
);

// File: tb/clkchg_seq_tb.sv
module clkchg_seq_tb;
   localparam logic [31:0] KEY = 32'hCF00_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pck_tick = 1'b0;
   logic        pll_lock = 1'b0;
   logic        sr_ack = 1'b0;
   logic        clkout_en_o, clkout_src_o, core_stall_o, sr_err_o;
   logic [11:0] div_act_o;
   logic [3:0]  mem_act_o;

   always #4 clk = ~clk;

   clkchg_seq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pck_tick(pck_tick),
      .pll_lock(pll_lock), .sr_ack(sr_ack), .clkout_en_o(clkout_en_o),
      .clkout_src_o(clkout_src_o), .core_stall_o(core_stall_o),
      .div_act_o(div_act_o), .mem_act_o(mem_act_o), .sr_err_o(sr_err_o)
   );

   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // peripheral tick every 4th system clock, driven off the active edge
   logic [1:0] tph = 2'd0;
   always @(negedge clk) begin
      tph = tph + 2'd1;
      pck_tick = (tph == 2'd0);
   end

   // phase tick counters, sampled with pre-edge output values
   int   g1 = 0, g2 = 0, wt = 0;
   logic lock_prev = 1'b0;
   always @(posedge clk) begin
      lock_prev <= pll_lock;
      if (clkout_en_o && !core_stall_o) begin
         g1 <= 0; g2 <= 0; wt <= 0;
      end else if (pck_tick) begin
         if (!clkout_en_o && !clkout_src_o) g1 <= g1 + 1;
         else if (!clkout_en_o && clkout_src_o && lock_prev) g2 <= g2 + 1;
         else if (clkout_en_o && core_stall_o) wt <= wt + 1;
      end
   end

   // scoreboard
   typedef struct {
      logic [11:0] div;
      logic [3:0]  mem;
      int          wdt;
   } exp_t;
   exp_t exq[$];

   logic prev_stall = 1'b0;
   always @(negedge clk) begin
      if (prev_stall && !core_stall_o) begin
         if (exq.size() == 0) begin
            chk(1'b0, "R7 unexpected completion", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exq.pop_front();
            chk(g1 == 10, "R3 ticks before source switch", g1, 10);
            chk(g2 == 10, "R4 ticks after lock", g2, 10);
            chk(wt == e.wdt, "R5 watchdog ticks", wt, e.wdt);
            chk(div_act_o == e.div, "R7 R8 active dividers", div_act_o, e.div);
            chk(mem_act_o == e.mem, "R7 R8 active memory field", mem_act_o, e.mem);
            chk(clkout_en_o && !clkout_src_o, "R11 resume state",
                {clkout_en_o, clkout_src_o}, 2'b10);
         end
      end
      prev_stall = core_stall_o;
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   logic [11:0] cur_div = '0;

   task automatic run_seq(input logic [11:0] dv, input logic [3:0] mv,
                          input int cmp, input int lockdly);
      logic [31:0] r;
      wr(2'd1, {12'h0, mv, 4'h0, dv});
      wr(2'd2, cmp);
      exq.push_back('{dv, mv, cmp + 1});
      wr(2'd0, KEY);
      chk(!clkout_en_o, "R2 enable low after key", clkout_en_o, 0);
      chk(core_stall_o, "R2 stall high after key", core_stall_o, 1);
      rd(2'd0, r);
      chk(r == KEY, "R6 control reads key while busy", r, KEY);
      chk(div_act_o == cur_div, "R7 dividers hold during change", div_act_o, cur_div);
      wr(2'd1, {12'h0, ~mv, 4'h0, ~dv});
      wr(2'd2, cmp + 7);
      while (!clkout_src_o) @(negedge clk);
      repeat (lockdly) @(negedge clk);
      pll_lock = 1'b1;
      while (core_stall_o) @(negedge clk);
      rd(2'd0, r);
      chk(r == 32'h0, "R6 control reads zero after completion", r, 0);
      rd(2'd1, r);
      chk(r == {12'h0, mv, 4'h0, dv}, "R8 staging kept during change", r,
          {12'h0, mv, 4'h0, dv});
      pll_lock = 1'b0;
      cur_div = dv;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(clkout_en_o == 1'b1, "R10 enable high", clkout_en_o, 1);
      chk(core_stall_o == 1'b0, "R10 stall low", core_stall_o, 0);
      chk(clkout_src_o == 1'b0, "R10 source low", clkout_src_o, 0);
      chk(div_act_o == 12'h0, "R10 dividers zero", div_act_o, 0);
      chk(sr_err_o == 1'b0, "R10 error clear", sr_err_o, 0);
      rd(2'd0, r);
      chk(r == 32'h0, "R10 control reads zero", r, 0);

      // R1 near-miss keys and wrong address
      wr(2'd0, KEY ^ 32'h1);
      chk(clkout_en_o && !core_stall_o, "R1 wrong key ignored",
          {clkout_en_o, core_stall_o}, 2'b10);
      wr(2'd0, KEY ^ 32'h8000_0000);
      chk(clkout_en_o && !core_stall_o, "R1 wrong key ignored (msb)",
          {clkout_en_o, core_stall_o}, 2'b10);
      wr(2'd2, KEY);
      chk(clkout_en_o && !core_stall_o, "R1 key at wrong address",
          {clkout_en_o, core_stall_o}, 2'b10);
      rd(2'd0, r);
      chk(r == 32'h0, "R1 control still zero", r, 0);

      // R2..R8, R11 full changes with various compare values
      run_seq(12'h321, 4'h0, 0, 3);
      run_seq(12'h5A7, 4'h0, 5, 0);
      run_seq(12'hFFF, 4'h0, 40, 17);

      // R9 memory field change without self-refresh
      wr(2'd1, 32'h0003_0123);
      sr_ack = 1'b0;
      wr(2'd0, KEY);
      chk(clkout_en_o && !core_stall_o, "R9 start refused",
          {clkout_en_o, core_stall_o}, 2'b10);
      chk(sr_err_o == 1'b1, "R9 error raised", sr_err_o, 1);
      rd(2'd3, r);
      chk(r[0] == 1'b1, "R9 status bit", r, 1);
      sr_ack = 1'b1;
      run_seq(12'h123, 4'h3, 1, 2);
      chk(sr_err_o == 1'b1, "R9 error sticky", sr_err_o, 1);

      repeat (4) @(negedge clk);
      chk(exq.size() == 0, "R7 scoreboard drained", exq.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule